// File: doc/BRIEF.md
# Double-Buffered Crossbar Switch

This block is a 32-input, 32-output non-blocking crossbar for single-bit data lanes. Every output owns a 32-to-1 selector and an enable bit. Any output can take any input, and any number of outputs can share one input. The data path from `sw_din` to `sw_dout` has no register in it. Only the routing map is held in registers.

Routing is written in two steps. First, each output's shadow entry is loaded one at a time. The load carries an output address, an input address and an enable bit. A single commit strobe then copies all shadow entries into the live map on one clock edge, so traffic never passes through a half-written map. Asserting load and commit together selects one of two reset modes, chosen by a mode pin. Broadcast routes every output from input 0 and enables every output. Disable-all turns every output off. Both modes act on the shadow map and the live map together.

Top module: `dbx_crossbar`

## Requirements
- R1: A synchronous active-high `rst` clears every shadow and live entry (enable 0, select 0). After reset, `sw_doe` and `sw_dout` are all zero, and a commit on its own keeps them all zero.
- R2: For each enabled output o with live select s, `sw_dout[o]` equals `sw_din[s]` in the same cycle, combinationally.
- R3: With `ld_stb`=1 and `cfg_stb`=0, the rising edge writes {`ld_en`, `ld_in_addr`} into the shadow entry of output `ld_out_addr` only. All other shadow entries keep their values.
- R4: Shadow writes do not change `sw_dout` or `sw_doe` until a commit occurs.
- R5: With `cfg_stb`=1 and `ld_stb`=0, the rising edge copies every shadow entry into the live map in that single cycle. Without a commit or a reset mode, the live map holds its value.
- R6: A disabled output drives `sw_doe[o]`=0 and `sw_dout[o]`=0 whatever the inputs are.
- R7: `ld_stb`=1, `cfg_stb`=1 and `rst_mode`=0 (broadcast) set every shadow and live entry to enable 1, select 0. From the next cycle, every output carries `sw_din[0]`.
- R8: `ld_stb`=1, `cfg_stb`=1 and `rst_mode`=1 (disable-all) clear the enable bit of every shadow and live entry. From the next cycle, `sw_doe` is all zero.
- R9: After either reset mode, a commit on its own does not bring back the routing that was in place before the mode pulse.
- R10: Several outputs may select the same input at once, and each of them carries that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_din | input | 32 | Data input lanes |
| ld_stb | input | 1 | Shadow-load strobe |
| cfg_stb | input | 1 | Commit strobe (with ld_stb: reset mode) |
| ld_out_addr | input | 5 | Output whose shadow entry is written |
| ld_in_addr | input | 5 | Input to select, captured on load |
| ld_en | input | 1 | Enable bit, captured on load |
| rst_mode | input | 1 | Reset mode: 0 broadcast, 1 disable-all |
| sw_dout | output | 32 | Data output lanes |
| sw_doe | output | 32 | Per-output enable |

## Verification
The assertions rely on the strobes and the mode pin being valid, non-X levels at every clock edge once reset is released. They also rely on a reset-mode pulse being recognised only through the coincidence of load and commit, with `ld_out_addr` ignored in that case. The bench meets both conditions. It drives every control input at the falling edge and holds each strobe for exactly one cycle. It returns both strobes to 0 between operations and keeps every address inside 0..31. It then samples the outputs at a later falling edge, after the new input pattern has settled.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int XB_PORTS = 32;
    localparam int XB_SEL_W = $clog2(XB_PORTS);

    typedef struct packed {
        logic                en;
        logic [XB_SEL_W-1:0] sel;
    } route_t;

    typedef enum logic {
        RM_BCAST = 1'b0,
        RM_OFF   = 1'b1
    } rmode_e;

    localparam route_t ROUTE_IDLE  = '{en: 1'b0, sel: '0};
    localparam route_t ROUTE_BCAST = '{en: 1'b1, sel: '0};

    function automatic logic route_pick(input logic [XB_PORTS-1:0] lanes,
                                        input route_t r);
        return r.en & lanes[r.sel];
    endfunction

endpackage

// File: rtl/xbar_addr_dec.sv
module xbar_addr_dec #(
    parameter int N = 32,
    localparam int W = $clog2(N)
) (
    input  logic         en,
    input  logic [W-1:0] addr,
    output logic [N-1:0] hot
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign hot[i] = en && (addr == W'(i));
    end
endmodule

// File: rtl/xbar_shadow_bank.sv
module xbar_shadow_bank
    import xbar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [XB_PORTS-1:0]   wr_hot,
    input  route_t                wr_entry,
    input  logic                  set_bcast,
    input  logic                  set_off,
    output route_t [XB_PORTS-1:0] shadow_q
);
    for (genvar i = 0; i < XB_PORTS; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                shadow_q[i] <= ROUTE_IDLE;
            else if (set_bcast)
                shadow_q[i] <= ROUTE_BCAST;
            else if (set_off)
                shadow_q[i].en <= 1'b0;
            else if (wr_hot[i])
                shadow_q[i] <= wr_entry;
        end

        // R3
        shadow_write_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_hot[i] && !set_bcast && !set_off) |=> shadow_q[i] == $past(wr_entry));

        // R3
        shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!wr_hot[i] && !set_bcast && !set_off) |=> $stable(shadow_q[i]));
    end
endmodule

// File: rtl/xbar_live_bank.sv
module xbar_live_bank
    import xbar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  commit,
    input  logic                  set_bcast,
    input  logic                  set_off,
    input  route_t [XB_PORTS-1:0] shadow_i,
    output route_t [XB_PORTS-1:0] live_q
);
    for (genvar i = 0; i < XB_PORTS; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                live_q[i] <= ROUTE_IDLE;
            else if (set_bcast)
                live_q[i] <= ROUTE_BCAST;
            else if (set_off)
                live_q[i].en <= 1'b0;
            else if (commit)
                live_q[i] <= shadow_i[i];
        end
    end

    // R5
    commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> live_q == $past(shadow_i));

    // R4
    live_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!commit && !set_bcast && !set_off) |=> $stable(live_q));
endmodule

// File: rtl/xbar_out_sel.sv
module xbar_out_sel
    import xbar_pkg::*;
(
    input  logic [XB_PORTS-1:0]   lanes,
    input  route_t [XB_PORTS-1:0] live_i,
    output logic [XB_PORTS-1:0]   dout,
    output logic [XB_PORTS-1:0]   doe
);
    for (genvar o = 0; o < XB_PORTS; o++) begin : g_out
        assign dout[o] = route_pick(lanes, live_i[o]);
        assign doe[o]  = live_i[o].en;
    end
endmodule

// File: rtl/dbx_crossbar.sv
module dbx_crossbar
    import xbar_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [XB_PORTS-1:0] sw_din,
    input  logic                ld_stb,
    input  logic                cfg_stb,
    input  logic [XB_SEL_W-1:0] ld_out_addr,
    input  logic [XB_SEL_W-1:0] ld_in_addr,
    input  logic                ld_en,
    input  logic                rst_mode,
    output logic [XB_PORTS-1:0] sw_dout,
    output logic [XB_PORTS-1:0] sw_doe
);
    rmode_e                mode;
    logic                  mode_pulse, do_bcast, do_off, do_load, do_commit;
    logic [XB_PORTS-1:0]   wr_hot;
    route_t                wr_entry;
    route_t [XB_PORTS-1:0] shadow_map;
    route_t [XB_PORTS-1:0] live_map;

    assign mode       = rmode_e'(rst_mode);
    assign mode_pulse = ld_stb & cfg_stb;
    assign do_bcast   = mode_pulse & (mode == RM_BCAST);
    assign do_off     = mode_pulse & (mode == RM_OFF);
    assign do_load    = ld_stb & ~cfg_stb;
    assign do_commit  = cfg_stb & ~ld_stb;
    assign wr_entry   = '{en: ld_en, sel: ld_in_addr};

    xbar_addr_dec #(.N(XB_PORTS)) u_dec (
        .en   (do_load),
        .addr (ld_out_addr),
        .hot  (wr_hot)
    );

    xbar_shadow_bank u_shadow (
        .clk       (clk),
        .rst       (rst),
        .wr_hot    (wr_hot),
        .wr_entry  (wr_entry),
        .set_bcast (do_bcast),
        .set_off   (do_off),
        .shadow_q  (shadow_map)
    );

    xbar_live_bank u_live (
        .clk       (clk),
        .rst       (rst),
        .commit    (do_commit),
        .set_bcast (do_bcast),
        .set_off   (do_off),
        .shadow_i  (shadow_map),
        .live_q    (live_map)
    );

    xbar_out_sel u_sel (
        .lanes  (sw_din),
        .live_i (live_map),
        .dout   (sw_dout),
        .doe    (sw_doe)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sw_doe == '0 && sw_dout == '0));

    // R6
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_dout & ~sw_doe) == '0);

    // R7
    bcast_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && cfg_stb && rst_mode == 1'b0) |=> sw_doe == '1);

    // R8
    off_all_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && cfg_stb && rst_mode == 1'b1) |=> sw_doe == '0);

    // R4
    load_no_live_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && !cfg_stb) |=> $stable(sw_doe));
endmodule

// File: tb/dbx_crossbar_test.sv
`timescale 1ns/1ps
module dbx_crossbar_test;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  sw_din = '0;
    logic          ld_stb = 1'b0, cfg_stb = 1'b0, ld_en = 1'b0, rst_mode = 1'b0;
    logic [4:0]    ld_out_addr = '0, ld_in_addr = '0;
    logic [N-1:0]  sw_dout, sw_doe;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    bit s_en [N]; int s_sel [N];
    bit a_en [N]; int a_sel [N];

    always #2.5 clk = ~clk;

    dbx_crossbar uut (
        .clk(clk), .rst(rst), .sw_din(sw_din), .ld_stb(ld_stb), .cfg_stb(cfg_stb),
        .ld_out_addr(ld_out_addr), .ld_in_addr(ld_in_addr), .ld_en(ld_en),
        .rst_mode(rst_mode), .sw_dout(sw_dout), .sw_doe(sw_doe)
    );

    task automatic check_now(input string tag);
        logic [N-1:0] e_out, e_oe;
        for (int o = 0; o < N; o++) begin
            e_oe[o]  = a_en[o];
            e_out[o] = a_en[o] & sw_din[a_sel[o]];
        end
        tests++;
        if (sw_dout !== e_out || sw_doe !== e_oe) begin
            fails++;
            $display("FAIL %s: dout=%h oe=%h expected dout=%h oe=%h",
                     tag, sw_dout, sw_doe, e_out, e_oe);
        end
    endtask

    task automatic check_pat(input logic [N-1:0] v, input string tag);
        sw_din = v;
        @(negedge clk);
        check_now(tag);
    endtask

    task automatic sweep(input string tag);
        check_pat(32'hFFFF_FFFF, tag);
        check_pat(32'h0000_0000, tag);
        check_pat(32'hA5A5_3C3C, tag);
        check_pat(32'h8000_0081, tag);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int o = 0; o < N; o++) begin
            s_en[o] = 0; s_sel[o] = 0; a_en[o] = 0; a_sel[o] = 0;
        end
    endtask

    task automatic load_one(input int o, input int i, input bit e);
        @(negedge clk);
        ld_stb = 1'b1; ld_out_addr = 5'(o); ld_in_addr = 5'(i); ld_en = e;
        @(negedge clk);
        ld_stb = 1'b0;
        s_en[o] = e; s_sel[o] = i;
    endtask

    task automatic commit();
        @(negedge clk); cfg_stb = 1'b1;
        @(negedge clk); cfg_stb = 1'b0;
        for (int o = 0; o < N; o++) begin a_en[o] = s_en[o]; a_sel[o] = s_sel[o]; end
    endtask

    task automatic mode_pulse(input bit m);
        @(negedge clk);
        ld_stb = 1'b1; cfg_stb = 1'b1; rst_mode = m; ld_out_addr = 5'd9;
        @(negedge clk);
        ld_stb = 1'b0; cfg_stb = 1'b0; rst_mode = 1'b0;
        for (int o = 0; o < N; o++) begin
            if (!m) begin s_en[o] = 1; s_sel[o] = 0; a_en[o] = 1; a_sel[o] = 0; end
            else begin s_en[o] = 0; a_en[o] = 0; end
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check_pat(32'hFFFF_FFFF, "R1 reset outputs off");
        commit();
        check_pat(32'hFFFF_FFFF, "R1 commit after reset stays off");
    endtask

    task automatic t_single_route();
        load_one(3, 7, 1);
        check_pat(32'hFFFF_FFFF, "R4 staged only, live unchanged");
        commit();
        check_pat(32'h0000_0080, "R2 out3 from in7 high");
        check_pat(32'hFFFF_FF7F, "R2 out3 from in7 low");
        sweep("R5 single commit");
    endtask

    task automatic t_multi_route();
        load_one(31, 31, 1);
        load_one(0, 31, 1);
        load_one(12, 31, 1);
        load_one(5, 2, 0);
        check_pat(32'hFFFF_FFFF, "R4 several staged, live unchanged");
        commit();
        check_pat(32'h8000_0000, "R10 fanout of in31");
        check_pat(32'h0000_0004, "R6 out5 disabled ignores in2");
        sweep("R3 only addressed entries written");
    endtask

    task automatic t_full_map();
        for (int o = 0; o < N; o++) load_one(o, (o * 7 + 3) % N, (o % 5) != 0);
        commit();
        sweep("R5 full map committed at once");
        for (int k = 0; k < N; k++) check_pat(32'(1) << k, "R2 walking one");
    endtask

    task automatic t_bcast();
        mode_pulse(1'b0);
        check_pat(32'h0000_0001, "R7 broadcast in0 high");
        check_pat(32'hFFFF_FFFE, "R7 broadcast in0 low");
        commit();
        check_pat(32'h5555_5555, "R9 commit after broadcast");
    endtask

    task automatic t_off();
        load_one(8, 4, 1);
        load_one(20, 17, 1);
        commit();
        check_pat(32'hFFFF_FFFF, "R2 before disable-all");
        mode_pulse(1'b1);
        check_pat(32'hFFFF_FFFF, "R8 disable-all");
        commit();
        check_pat(32'hFFFF_FFFF, "R9 commit after disable-all");
        load_one(8, 4, 1);
        commit();
        check_pat(32'h0000_0010, "R3 reload after disable-all");
    endtask

    task automatic t_reset_mid();
        load_one(1, 1, 1);
        commit();
        do_reset();
        check_pat(32'hFFFF_FFFF, "R1 reset mid-run");
        commit();
        check_pat(32'hFFFF_FFFF, "R1 shadow cleared by reset");
    endtask

    initial begin
        t_reset_state();
        t_single_route();
        t_multi_route();
        t_full_map();
        t_bcast();
        t_off();
        t_reset_mid();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule